// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory cycles of a small 8-bit controller core. The core hands it one request at a time: an instruction fetch, a data read or write with a full 16-bit address, or a data read or write with a short 8-bit address. The block then drives a shared port that carries the low address byte and then the data byte. It also drives a port for the high address byte, an address latch strobe, and three active-low strobes: one for program fetch, one for data read and one for data write. When the cycle ends, it returns a one-cycle completion pulse, with read data where the request was a read.

An external cycle has four phases of one clock each. In the address phase the low address is driven and the latch strobe is high. In the latch phase the latch strobe falls. In the strobe phase exactly one strobe is low. In the release phase the strobe returns high. The block also keeps the software latches of both ports. An external access destroys the low port's latch. Short-address accesses let the high port's latch show on the pins, so software can use it as a page register.

A configuration bit can silence the address latch strobe completely. This is useful in systems that have no external memory. A second bit enables an on-chip expansion RAM. When it is set, data accesses that the RAM claims are served in a single internal cycle and nothing moves on the bus. A 16-bit access is claimed only when its upper byte falls in a page window set by parameters. An 8-bit access is always claimed. A fetch is never claimed.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: Out of reset, and between cycles, `req_ready` is 1. The strobes `psen_n`, `rd_n` and `wr_n` are 1, `ale` is 0 and `p0_drive` is 0. `p0_out` shows the low-port latch and `p2_out` shows the high-port latch. Both latches reset to FFh. Writing a latch through its write-enable input updates the latch and the idle pin value.
- R2: An external cycle starts on the clock edge that accepts the request. It then passes through the address phase, the latch phase, the strobe phase and the release phase, one clock each. In the address and latch phases `p0_out` carries `req_addr[7:0]` with `p0_drive`=1. `ale` is 1 only in the address phase. `done` is 1 only in the release phase.
- R3: `req_kind` 0 (fetch) lowers only `psen_n`, in the strobe phase. `p2_out` carries `req_addr[15:8]` through the address, latch and strobe phases.
- R4: `req_kind` 1 (16-bit read) and 3 (8-bit read) lower only `rd_n`, with `p0_drive`=0. The value on `p0_in` during the strobe phase comes back on `rdata` together with `done`.
- R5: `req_kind` 2 (16-bit write) and 4 (8-bit write) lower only `wr_n`. During the strobe phase `p0_out` carries `req_wdata` with `p0_drive`=1.
- R6: For kinds 1 and 2, `p2_out` carries `req_addr[15:8]` through the address, latch and strobe phases. The high-port latch keeps its value.
- R7: For kinds 3 and 4, `p2_out` shows the high-port latch through the whole cycle.
- R8: Every external cycle leaves the low-port latch at FFh. A cycle served internally leaves that latch unchanged.
- R9: While `cfg_ale_en` is 0, `ale` stays 0. Phase timing and all other outputs behave as in R2.
- R10: While `cfg_xram_en` is 1, a kind 1 or 2 access whose upper address byte lies within the page window (default FFh only) is served internally. For one clock `xram_sel` is 1, with `xram_addr`, `xram_wdata`, and `xram_we` set for writes. No strobe moves, `ale` stays 0 and `p0_drive` stays 0. On the next clock `done` is 1 with `served_int`=1, and for reads `rdata` equals `xram_rdata` as sampled in that one clock.
- R11: While `cfg_xram_en` is 1, every kind 3 or 4 access is served internally as in R10, whatever its address.
- R12: A fetch is always external. With `cfg_xram_en` at 0, or for a 16-bit data address outside the window, the access is external and `served_int` is 0 with `done`.
- R13: At no time is more than one of `psen_n`, `rd_n` and `wr_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ale_en | input | 1 | 1 lets the address latch strobe toggle |
| cfg_xram_en | input | 1 | 1 enables the on-chip expansion RAM |
| req_valid | input | 1 | Request present, taken when `req_ready` is 1 |
| req_kind | input | 3 | 0 fetch, 1 read16, 2 write16, 3 read8, 4 write8 |
| req_addr | input | 16 | Request address (upper byte unused for kinds 3, 4) |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| served_int | output | 1 | With `done`: access went to the internal RAM |
| rdata | output | 8 | Read data, valid with `done` for reads |
| p0_lat_we | input | 1 | Write strobe for the low-port latch |
| p0_lat_wdata | input | 8 | Value for the low-port latch |
| p2_lat_we | input | 1 | Write strobe for the high-port latch |
| p2_lat_wdata | input | 8 | Value for the high-port latch |
| p0_lat | output | 8 | Current low-port latch |
| p2_lat | output | 8 | Current high-port latch |
| p0_in | input | 8 | Low-port pin input |
| p0_out | output | 8 | Low-port pin output value |
| p0_drive | output | 1 | 1 = low port actively driven by the bus |
| p2_out | output | 8 | High-port pin output value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| xram_sel | output | 1 | Internal RAM access this clock |
| xram_we | output | 1 | Internal RAM write |
| xram_addr | output | 16 | Internal RAM address |
| xram_wdata | output | 8 | Internal RAM write data |
| xram_rdata | input | 8 | Internal RAM read data |

## Verification
The properties assume that `req_kind` never carries codes 5 to 7. They also assume that the high-port latch is not rewritten while a short-address strobe is low, because the check that `p2_out` holds steady under a strobe relies on that. The stimulus writes the latches only while the block is idle, and it draws request kinds only from the five defined codes. It changes the configuration bits only between cycles, so the gating of the latch strobe and the routing of each request are decided under settled settings.

// File: rtl/xmem_pkg.sv
// Shared codes for the external memory bus controller.
// Assumes: request kinds 5..7 are never presented.
package xmem_pkg;

    localparam logic [2:0] K_FETCH = 3'd0;
    localparam logic [2:0] K_RD16  = 3'd1;
    localparam logic [2:0] K_WR16  = 3'd2;
    localparam logic [2:0] K_RD8   = 3'd3;
    localparam logic [2:0] K_WR8   = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_LATCH = 3'd2,
        PH_STRB  = 3'd3,
        PH_REL   = 3'd4,
        PH_INT   = 3'd5
    } phase_e;

    function automatic logic kind_is_write(input logic [2:0] k);
        return (k == K_WR16) || (k == K_WR8);
    endfunction

    function automatic logic kind_is_read(input logic [2:0] k);
        return (k == K_RD16) || (k == K_RD8);
    endfunction

    function automatic logic kind_is_short(input logic [2:0] k);
        return (k == K_RD8) || (k == K_WR8);
    endfunction

    function automatic logic kind_is_data16(input logic [2:0] k);
        return (k == K_RD16) || (k == K_WR16);
    endfunction

endpackage

// File: rtl/xmem_route.sv
// Decides whether a data request is claimed by the on-chip expansion RAM.
// Short-address data requests are always claimed when the RAM is enabled;
// long-address data requests only when the upper byte lies in the page
// window [PAGE_FIRST, PAGE_LAST]; fetches never.
// Assumes: PAGE_FIRST <= PAGE_LAST, both fit in ADDR_W-DATA_W bits.
module xmem_route
    import xmem_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_FIRST = 'hFF,
    parameter int PAGE_LAST  = 'hFF
) (
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              xram_en,
    output logic              go_int
);

    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [HI_W-1:0] PF = HI_W'(PAGE_FIRST);
    localparam logic [HI_W-1:0] PL = HI_W'(PAGE_LAST);

    logic [HI_W-1:0] page;
    logic            above_first;
    logic            below_last;

    assign page = addr[ADDR_W-1:DATA_W];

    // Lower bound: omitted when the window starts at page zero.
    generate
        if (PAGE_FIRST == 0) begin : g_lo_open
            assign above_first = 1'b1;
        end else begin : g_lo_cmp
            assign above_first = (page >= PF);
        end
    endgenerate

    // Upper bound: omitted when the window reaches the top page.
    generate
        if (PL == {HI_W{1'b1}}) begin : g_hi_open
            assign below_last = 1'b1;
        end else begin : g_hi_cmp
            assign below_last = (page <= PL);
        end
    endgenerate

    // Claim decision for the current request.
    always_comb begin
        go_int = 1'b0;
        if (xram_en) begin
            if (kind_is_short(kind))
                go_int = 1'b1;
            else if (kind_is_data16(kind))
                go_int = above_first && below_last;
        end
    end

endmodule

// File: rtl/xmem_seq.sv
// Phase sequencer: accepts one request when idle, captures it, and steps
// through address, latch, strobe and release phases (or a single internal
// phase). Produces the completion pulse and read data one clock after the
// strobe or internal phase.
// Assumes: the route decision is valid in the same clock as req_valid.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              go_int,
    input  logic [DATA_W-1:0] p0_in,
    input  logic [DATA_W-1:0] xram_rdata,
    output phase_e            phase,
    output logic [2:0]        cur_kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              req_ready,
    output logic              accept_ext,
    output logic              done,
    output logic              served_int,
    output logic [DATA_W-1:0] rdata
);

    assign req_ready  = (phase == PH_IDLE);
    assign accept_ext = req_ready && req_valid && !go_int;

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cur_kind  <= K_FETCH;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase     <= go_int ? PH_INT : PH_ADDR;
                        cur_kind  <= req_kind;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                    end
                end
                PH_ADDR:  phase <= PH_LATCH;
                PH_LATCH: phase <= PH_STRB;
                PH_STRB:  phase <= PH_REL;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Completion pulse, routing flag and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            served_int <= 1'b0;
            rdata      <= '0;
        end else begin
            done       <= (phase == PH_STRB) || (phase == PH_INT);
            served_int <= (phase == PH_INT);
            if (kind_is_read(cur_kind)) begin
                if (phase == PH_STRB)
                    rdata <= p0_in;
                else if (phase == PH_INT)
                    rdata <= xram_rdata;
            end
        end
    end

endmodule

// File: rtl/xmem_pins.sv
// Pin and latch stage: holds both software port latches, wipes the low
// latch to all ones when an external cycle is accepted, and derives the
// port values, the drive enable and all strobes from the current phase.
// Assumes: phase, kind, addr and wdata are stable for a whole phase.
module xmem_pins
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase,
    input  logic [2:0]               kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     accept_ext,
    input  logic                     cfg_ale_en,
    input  logic                     p0_lat_we,
    input  logic [DATA_W-1:0]        p0_lat_wdata,
    input  logic                     p2_lat_we,
    input  logic [ADDR_W-DATA_W-1:0] p2_lat_wdata,
    output logic [DATA_W-1:0]        p0_lat,
    output logic [ADDR_W-DATA_W-1:0] p2_lat,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_drive,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     xram_sel,
    output logic                     xram_we
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic addr_ph;
    logic strb_ph;
    logic in_bus;
    logic long_addr;

    assign addr_ph   = (phase == PH_ADDR) || (phase == PH_LATCH);
    assign strb_ph   = (phase == PH_STRB);
    assign in_bus    = addr_ph || strb_ph;
    assign long_addr = !kind_is_short(kind);

    // Low-port latch: an accepted external cycle overrides software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            p0_lat <= '1;
        else if (accept_ext)
            p0_lat <= '1;
        else if (p0_lat_we)
            p0_lat <= p0_lat_wdata;
    end

    // High-port latch: only software writes touch it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            p2_lat <= '1;
        else if (p2_lat_we)
            p2_lat <= p2_lat_wdata;
    end

    // Strobes: one at most, only in the strobe phase.
    always_comb begin
        ale    = cfg_ale_en && (phase == PH_ADDR);
        psen_n = !(strb_ph && (kind == K_FETCH));
        rd_n   = !(strb_ph && kind_is_read(kind));
        wr_n   = !(strb_ph && kind_is_write(kind));
    end

    // Low port: address, then write data, else the latch.
    always_comb begin
        p0_drive = addr_ph || (strb_ph && kind_is_write(kind));
        if (addr_ph)
            p0_out = addr[DATA_W-1:0];
        else if (strb_ph && kind_is_write(kind))
            p0_out = wdata;
        else
            p0_out = p0_lat;
    end

    // High port: upper address for long cycles, else the latch (paging).
    always_comb begin
        if (in_bus && long_addr)
            p2_out = addr[ADDR_W-1:DATA_W];
        else
            p2_out = p2_lat;
    end

    // Internal RAM access controls.
    always_comb begin
        xram_sel = (phase == PH_INT);
        xram_we  = (phase == PH_INT) && kind_is_write(kind);
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/xmem_bus_ctrl.sv
// Top of the multiplexed external memory bus controller. Routes each
// request to the external bus or the on-chip expansion RAM and wires the
// sequencer to the pin stage.
// Assumes: ADDR_W = 2*DATA_W style split (low byte multiplexed on port 0).
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_FIRST = 'hFF,
    parameter int PAGE_LAST  = 'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_ale_en,
    input  logic                     cfg_xram_en,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     done,
    output logic                     served_int,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     p0_lat_we,
    input  logic [DATA_W-1:0]        p0_lat_wdata,
    input  logic                     p2_lat_we,
    input  logic [ADDR_W-DATA_W-1:0] p2_lat_wdata,
    output logic [DATA_W-1:0]        p0_lat,
    output logic [ADDR_W-DATA_W-1:0] p2_lat,
    input  logic [DATA_W-1:0]        p0_in,
    output logic [DATA_W-1:0]        p0_out,
    output logic                     p0_drive,
    output logic [ADDR_W-DATA_W-1:0] p2_out,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     xram_sel,
    output logic                     xram_we,
    output logic [ADDR_W-1:0]        xram_addr,
    output logic [DATA_W-1:0]        xram_wdata,
    input  logic [DATA_W-1:0]        xram_rdata
);

    phase_e            phase;
    logic [2:0]        cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              go_int;
    logic              accept_ext;

    xmem_route #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PAGE_FIRST(PAGE_FIRST), .PAGE_LAST(PAGE_LAST)
    ) u_route (
        .kind    (req_kind),
        .addr    (req_addr),
        .xram_en (cfg_xram_en),
        .go_int  (go_int)
    );

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .go_int     (go_int),
        .p0_in      (p0_in),
        .xram_rdata (xram_rdata),
        .phase      (phase),
        .cur_kind   (cur_kind),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .req_ready  (req_ready),
        .accept_ext (accept_ext),
        .done       (done),
        .served_int (served_int),
        .rdata      (rdata)
    );

    xmem_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .kind         (cur_kind),
        .addr         (cur_addr),
        .wdata        (cur_wdata),
        .accept_ext   (accept_ext),
        .cfg_ale_en   (cfg_ale_en),
        .p0_lat_we    (p0_lat_we),
        .p0_lat_wdata (p0_lat_wdata),
        .p2_lat_we    (p2_lat_we),
        .p2_lat_wdata (p2_lat_wdata),
        .p0_lat       (p0_lat),
        .p2_lat       (p2_lat),
        .p0_out       (p0_out),
        .p0_drive     (p0_drive),
        .p2_out       (p2_out),
        .ale          (ale),
        .psen_n       (psen_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .xram_sel     (xram_sel),
        .xram_we      (xram_we)
    );

    assign xram_addr  = cur_addr;
    assign xram_wdata = cur_wdata;

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
// Property checker for the bus controller, attached by bind.
// Assumes: reset is low from time zero until the first edges.
module xmem_bus_ctrl_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_ale_en,
    input logic            ale,
    input logic            psen_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            p0_drive,
    input logic [HI_W-1:0] p2_out,
    input logic            xram_sel,
    input logic            done
);

    assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    assert_ale_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ale_en |-> !ale);

    assert_int_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xram_sel |-> (psen_n && rd_n && wr_n && !ale && !p0_drive));

    assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_drive);

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> p0_drive);

    assert_p2_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |-> $stable(p2_out));

    assert_done_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |=> done);

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ale_en (cfg_ale_en),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .p0_drive   (p0_drive),
    .p2_out     (p2_out),
    .xram_sel   (xram_sel),
    .done       (done)
);

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ale_en = 1'b1;
    logic        cfg_xram_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, served_int;
    logic [7:0]  rdata;
    logic        p0_lat_we = 1'b0;
    logic [7:0]  p0_lat_wdata = '0;
    logic        p2_lat_we = 1'b0;
    logic [7:0]  p2_lat_wdata = '0;
    logic [7:0]  p0_lat, p2_lat;
    logic [7:0]  p0_in = '0;
    logic [7:0]  p0_out;
    logic        p0_drive;
    logic [7:0]  p2_out;
    logic        ale, psen_n, rd_n, wr_n;
    logic        xram_sel, xram_we;
    logic [15:0] xram_addr;
    logic [7:0]  xram_wdata;
    logic [7:0]  xram_rdata = '0;

    always #2.5 clk = ~clk;

    xmem_bus_ctrl u0 (.*);

    int nchk = 0;
    int nerr = 0;
    logic [7:0] m_p0 = 8'hFF;
    logic [7:0] m_p2 = 8'hFF;

    typedef struct packed {
        logic [7:0] rd;
        logic       is_rd;
        logic       intl;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every completion pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected done", 32'(done), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(served_int == e.intl, "R12/R10 served_int", 32'(served_int), 32'(e.intl));
                if (e.is_rd)
                    chk(rdata == e.rd, "R4/R10 rdata", 32'(rdata), 32'(e.rd));
            end
        end
    end

    task automatic set_lat(input logic [7:0] v0, input logic [7:0] v2);
        @(negedge clk);
        p0_lat_we = 1'b1; p0_lat_wdata = v0;
        p2_lat_we = 1'b1; p2_lat_wdata = v2;
        @(negedge clk);
        p0_lat_we = 1'b0; p2_lat_we = 1'b0;
        m_p0 = v0; m_p2 = v2;
        chk(p0_out == v0 && p0_lat == v0, "R1 p0 latch idle", 32'(p0_out), 32'(v0));
        chk(p2_out == v2 && p2_lat == v2, "R1 p2 latch idle", 32'(p2_out), 32'(v2));
    endtask

    // Driver for an external cycle with phase-by-phase checks.
    task automatic ext_acc(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] pin);
        logic is_w, is_r, is_short;
        logic [7:0] exp_p2;
        exp_t e;
        is_w = (k == 3'd2) || (k == 3'd4);
        is_r = (k == 3'd1) || (k == 3'd3);
        is_short = (k == 3'd3) || (k == 3'd4);
        exp_p2 = is_short ? m_p2 : a[15:8];
        e.rd = pin; e.is_rd = is_r; e.intl = 1'b0;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; p0_in = pin;
        @(negedge clk);
        req_valid = 1'b0;
        // address phase
        chk(ale == cfg_ale_en, "R2/R9 ale in address phase", 32'(ale), 32'(cfg_ale_en));
        chk(p0_out == a[7:0] && p0_drive, "R2 low address driven", 32'(p0_out), 32'(a[7:0]));
        chk(p2_out == exp_p2, "R3/R6/R7 p2 address phase", 32'(p2_out), 32'(exp_p2));
        chk(psen_n && rd_n && wr_n, "R2 strobes idle in address phase", 32'({psen_n, rd_n, wr_n}), 32'd7);
        @(negedge clk);
        // latch phase
        chk(!ale && p0_out == a[7:0] && p0_drive, "R2 latch phase", 32'({ale, p0_out}), 32'(a[7:0]));
        @(negedge clk);
        // strobe phase
        chk(psen_n == (k != 3'd0), "R3 psen_n strobe", 32'(psen_n), 32'(k != 3'd0));
        chk(rd_n == !is_r, "R4 rd_n strobe", 32'(rd_n), 32'(!is_r));
        chk(wr_n == !is_w, "R5 wr_n strobe", 32'(wr_n), 32'(!is_w));
        chk(p0_drive == is_w, "R4/R5 p0 drive in strobe", 32'(p0_drive), 32'(is_w));
        if (is_w)
            chk(p0_out == wd, "R5 write data", 32'(p0_out), 32'(wd));
        chk(p2_out == exp_p2, "R3/R6/R7 p2 strobe phase", 32'(p2_out), 32'(exp_p2));
        chk(!ale, "R9 ale low in strobe", 32'(ale), 32'd0);
        @(negedge clk);
        // release phase
        m_p0 = 8'hFF;
        chk(done == 1'b1, "R2 done in release", 32'(done), 32'd1);
        chk(psen_n && rd_n && wr_n && !p0_drive, "R2 release", 32'({psen_n, rd_n, wr_n, p0_drive}), 32'hE);
        chk(p0_lat == 8'hFF, "R8 p0 latch wiped", 32'(p0_lat), 32'hFF);
        chk(p2_lat == m_p2 && p2_out == m_p2, "R6 p2 latch kept", 32'(p2_lat), 32'(m_p2));
        @(negedge clk);
        chk(req_ready && !done, "R1 idle after cycle", 32'({req_ready, done}), 32'h2);
    endtask

    // Driver for an access the internal RAM must claim.
    task automatic int_acc(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] xrd);
        logic is_w, is_r;
        exp_t e;
        is_w = (k == 3'd2) || (k == 3'd4);
        is_r = (k == 3'd1) || (k == 3'd3);
        e.rd = xrd; e.is_rd = is_r; e.intl = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; xram_rdata = xrd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(xram_sel && xram_we == is_w, "R10/R11 internal select", 32'({xram_sel, xram_we}), 32'({1'b1, is_w}));
        chk(xram_addr == a, "R10/R11 internal address", 32'(xram_addr), 32'(a));
        if (is_w)
            chk(xram_wdata == wd, "R10/R11 internal write data", 32'(xram_wdata), 32'(wd));
        chk(psen_n && rd_n && wr_n && !ale && !p0_drive, "R10/R11 bus quiet",
            32'({psen_n, rd_n, wr_n, ale, p0_drive}), 32'h1C);
        chk(p0_out == m_p0 && p2_out == m_p2, "R10/R11 ports show latches", 32'({p0_out, p2_out}), 32'({m_p0, m_p2}));
        @(negedge clk);
        chk(done == 1'b1 && !xram_sel, "R10 done next clock", 32'({done, xram_sel}), 32'h2);
        chk(p0_lat == m_p0, "R8 latch kept on internal", 32'(p0_lat), 32'(m_p0));
        @(negedge clk);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && psen_n && rd_n && wr_n && !ale && !p0_drive && !done, "R1 reset outputs",
            32'({req_ready, psen_n, rd_n, wr_n, ale, p0_drive, done}), 32'h78);
        chk(p0_lat == 8'hFF && p2_lat == 8'hFF && p0_out == 8'hFF && p2_out == 8'hFF, "R1 reset latches",
            32'({p0_lat, p2_lat}), 32'hFFFF);
        set_lat(8'h5A, 8'h3C);
        ext_acc(3'd0, 16'h1234, 8'h00, 8'h00);      // R3 fetch
        ext_acc(3'd1, 16'hABCD, 8'h00, 8'h77);      // R4, R6 read16
        ext_acc(3'd2, 16'h8001, 8'hE5, 8'h00);      // R5, R6 write16
        ext_acc(3'd3, 16'h0042, 8'h00, 8'hC3);      // R7 read8
        ext_acc(3'd4, 16'h0099, 8'h1F, 8'h00);      // R7 write8
        cfg_ale_en = 1'b0;
        ext_acc(3'd0, 16'h4321, 8'h00, 8'h00);      // R9 fetch with ale off
        ext_acc(3'd1, 16'h0F0F, 8'h00, 8'hA5);      // R9 read16 with ale off
        cfg_ale_en = 1'b1;
        ext_acc(3'd1, 16'hFF20, 8'h00, 8'h3E);      // R12 xram off, in window
        cfg_xram_en = 1'b1;
        set_lat(8'h11, 8'h22);
        int_acc(3'd1, 16'hFF10, 8'h00, 8'h99);      // R10 read16 in window
        int_acc(3'd2, 16'hFFFE, 8'h6B, 8'h00);      // R10 write16 in window
        int_acc(3'd4, 16'h0005, 8'h4D, 8'h00);      // R11 write8
        int_acc(3'd3, 16'h00F0, 8'h00, 8'h2C);      // R11 read8
        ext_acc(3'd1, 16'hFE00, 8'h00, 8'h81);      // R12 outside window
        ext_acc(3'd0, 16'hFF00, 8'h00, 8'h00);      // R12 fetch never internal
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R2 all completions seen", 32'(sb.size()), 32'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                nchk++; nerr++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule